// File: doc/BRIEF.md
# Security Attribution Unit with External Attribution Merge

This block decides, for every address a core presents, whether that address belongs to the Secure world, the Non-secure world, or is a Non-secure-callable entry area inside the Secure world. Software programs a set of base/limit address windows and a two-bit mode control. In parallel, an implementation-defined attribution source outside the block gives its own opinion about the same address: whether it is exempt from attribution, whether it is Non-secure, and whether it is callable.

The block evaluates all windows at once, resolves multiple hits, and merges its answer with the external opinion so that the more secure of the two wins. It also reports which window matched and whether any window edge falls inside the page holding the address, so a translation cache knows the result cannot be reused for the whole page. Every result is registered and appears one cycle after the lookup strobe.

Top module: `sec_attr_unit`

## Requirements
- R1: With mode bit 0 clear, the unit matches no window: mode bits 1:0 = 00 gives Secure (ns_o=0, nsc_o=0) and 10 gives Non-secure (ns_o=1), both with rgn_hit_o=0 and rgn_idx_o=0 before the external merge.
- R2: A window takes part only when bit 0 of its limit word is set; it covers every address from its base word with bits [4:0] forced to 0 up to its limit word with bits [4:0] forced to 1, both ends included.
- R3: With mode bit 0 set and exactly one window hit, rgn_hit_o=1 and rgn_idx_o gives that window's index; the address is Non-secure (ns_o=1, nsc_o=0) unless bit 1 of the window's limit word is set, in which case nsc_o=1 and ns_o=0.
- R4: Two or more hitting windows give Secure, not callable, rgn_idx_o=0 and rgn_hit_o=0.
- R5: With mode bit 0 set and no window hit, the result is Secure with rgn_hit_o=0 and rgn_idx_o=0.
- R6: When the external source reports Secure (ext_ns_i=0) and the unit's answer is Non-secure, or callable while ext_nsc_i=0, the answer becomes Secure with nsc_o taken from ext_nsc_i; otherwise the unit's answer stands.
- R7: An exempt address (ext_exempt_i=1) yields ns_o equal to the inverse of cur_secure_i, with nsc_o, rgn_hit_o, rgn_idx_o and subpage_o all 0.
- R8: subpage_o is 1 when mode bit 0 is set, the address is not exempt, and some enabled window overlaps the 2^PAGE_BITS-byte page holding the address without covering all of it.
- R9: Results and valid_o are registered: valid_o is lookup_i delayed by one cycle, outputs change only in the cycle after a lookup and hold otherwise; reset clears every output to 0.
- R10: ns_o and nsc_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_i | input | 1 | Lookup strobe for addr_i |
| addr_i | input | ADDR_W | Address to classify |
| cur_secure_i | input | 1 | Current security state of the core |
| ctrl_i | input | 2 | Mode: bit 0 window checking, bit 1 all Non-secure when checking is off |
| rgn_base_i | input | NUM_RGN*ADDR_W | Base words, window i at bits [i*ADDR_W +: ADDR_W] |
| rgn_limit_i | input | NUM_RGN*ADDR_W | Limit words (bit 0 enable, bit 1 callable), same packing |
| ext_exempt_i | input | 1 | External source: address exempt from attribution |
| ext_ns_i | input | 1 | External source: address Non-secure |
| ext_nsc_i | input | 1 | External source: address callable |
| valid_o | output | 1 | Result valid (lookup one cycle earlier) |
| ns_o | output | 1 | Address is Non-secure |
| nsc_o | output | 1 | Address is Non-secure-callable |
| rgn_idx_o | output | IDX_W | Index of the single matching window |
| rgn_hit_o | output | 1 | rgn_idx_o is meaningful |
| subpage_o | output | 1 | A window edge lies inside the address's page |

## Verification
Every cycle, the assertions check the one-cycle latency and hold behaviour, the exclusivity of ns_o and nsc_o, the fixed outcomes of the two non-checking modes, exempt handling, the Secure override from the external source, and that a valid window index only appears in checking mode. Which window wins, the fall-back on overlapping windows, the inclusive edges of each window and the page-straddle flag depend on programmed addresses and can only be shown by the bench's directed cases and its seeded random lookups against a reference model.

// File: rtl/sec_attr_pkg.sv
package sec_attr_pkg;

  localparam int unsigned GRAN_BITS = 5;

  typedef struct packed {
    logic exempt;
    logic ns;
    logic nsc;
  } ext_attr_t;

  typedef struct packed {
    logic ns;
    logic nsc;
    logic hit;
    logic subpage;
  } attr_flags_t;

  localparam int unsigned CTRL_CHK_BIT  = 0;
  localparam int unsigned CTRL_ALLNS_BIT = 1;
  localparam int unsigned LIM_EN_BIT    = 0;
  localparam int unsigned LIM_NSC_BIT   = 1;

endpackage

// File: rtl/sec_attr_rgn_match.sv
module sec_attr_rgn_match
  import sec_attr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              nsc_o,
  output logic              partial_o
);
  localparam logic [ADDR_W-1:0] GMASK = ADDR_W'((64'd1 << GRAN_BITS) - 64'd1);
  localparam logic [ADDR_W-1:0] PMASK = ADDR_W'((64'd1 << PAGE_BITS) - 64'd1);

  logic              en;
  logic [ADDR_W-1:0] lo, hi, pg_lo, pg_hi;
  logic              overlap;

  assign en    = limit_i[LIM_EN_BIT];
  assign lo    = base_i & ~GMASK;
  assign hi    = limit_i | GMASK;
  assign pg_lo = addr_i & ~PMASK;
  assign pg_hi = addr_i | PMASK;

  assign hit_o     = en && (addr_i >= lo) && (addr_i <= hi);
  assign nsc_o     = limit_i[LIM_NSC_BIT];
  assign overlap   = en && (lo <= pg_hi) && (hi >= pg_lo);
  assign partial_o = overlap && ((lo > pg_lo) || (hi < pg_hi));
endmodule

// File: rtl/sec_attr_resolve.sv
module sec_attr_resolve
  import sec_attr_pkg::*;
#(
  parameter int unsigned NUM_RGN = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [NUM_RGN-1:0] hit_i,
  input  logic [NUM_RGN-1:0] nsc_i,
  input  logic [NUM_RGN-1:0] partial_i,
  input  logic [1:0]         ctrl_i,
  input  logic               cur_secure_i,
  input  ext_attr_t          ext_i,
  output attr_flags_t        flags_o,
  output logic [IDX_W-1:0]   idx_o
);
  localparam int unsigned CNT_W = $clog2(NUM_RGN + 1);

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] first;

  always_comb begin
    cnt   = '0;
    first = '0;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        cnt   = cnt + CNT_W'(1);
        first = IDX_W'(i);
      end
    end
  end

  always_comb begin
    flags_o = '0;
    idx_o   = '0;
    if (ctrl_i[CTRL_CHK_BIT]) begin
      flags_o.subpage = |partial_i;
      if (cnt == CNT_W'(1)) begin
        flags_o.hit = 1'b1;
        idx_o       = first;
        flags_o.nsc = nsc_i[first];
        flags_o.ns  = ~nsc_i[first];
      end
      // zero or several hits: Secure, no region
    end else if (ctrl_i[CTRL_ALLNS_BIT]) begin
      flags_o.ns = 1'b1;
    end
    // more secure answer wins
    if (!ext_i.ns && (flags_o.ns || (flags_o.nsc && !ext_i.nsc))) begin
      flags_o.ns  = 1'b0;
      flags_o.nsc = ext_i.nsc;
    end
    if (ext_i.exempt) begin
      flags_o    = '0;
      flags_o.ns = ~cur_secure_i;
      idx_o      = '0;
    end
  end
endmodule

// File: rtl/sec_attr_unit.sv
module sec_attr_unit
  import sec_attr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_RGN   = 8,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned IDX_W    = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      lookup_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      cur_secure_i,
  input  logic [1:0]                ctrl_i,
  input  logic [NUM_RGN*ADDR_W-1:0] rgn_base_i,
  input  logic [NUM_RGN*ADDR_W-1:0] rgn_limit_i,
  input  logic                      ext_exempt_i,
  input  logic                      ext_ns_i,
  input  logic                      ext_nsc_i,
  output logic                      valid_o,
  output logic                      ns_o,
  output logic                      nsc_o,
  output logic [IDX_W-1:0]          rgn_idx_o,
  output logic                      rgn_hit_o,
  output logic                      subpage_o
);
  logic [NUM_RGN-1:0] hit_v, nsc_v, part_v;
  attr_flags_t        flags_d;
  logic [IDX_W-1:0]   idx_d;
  ext_attr_t          ext;

  assign ext = '{exempt: ext_exempt_i, ns: ext_ns_i, nsc: ext_nsc_i};

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    sec_attr_rgn_match #(
      .ADDR_W   (ADDR_W),
      .PAGE_BITS(PAGE_BITS)
    ) u_match (
      .base_i   (rgn_base_i[g*ADDR_W +: ADDR_W]),
      .limit_i  (rgn_limit_i[g*ADDR_W +: ADDR_W]),
      .addr_i   (addr_i),
      .hit_o    (hit_v[g]),
      .nsc_o    (nsc_v[g]),
      .partial_o(part_v[g])
    );
  end

  sec_attr_resolve #(
    .NUM_RGN(NUM_RGN),
    .IDX_W  (IDX_W)
  ) u_resolve (
    .hit_i       (hit_v),
    .nsc_i       (nsc_v),
    .partial_i   (part_v),
    .ctrl_i      (ctrl_i),
    .cur_secure_i(cur_secure_i),
    .ext_i       (ext),
    .flags_o     (flags_d),
    .idx_o       (idx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      ns_o      <= 1'b0;
      nsc_o     <= 1'b0;
      rgn_idx_o <= '0;
      rgn_hit_o <= 1'b0;
      subpage_o <= 1'b0;
    end else begin
      valid_o <= lookup_i;
      if (lookup_i) begin
        ns_o      <= flags_d.ns;
        nsc_o     <= flags_d.nsc;
        rgn_idx_o <= idx_d;
        rgn_hit_o <= flags_d.hit;
        subpage_o <= flags_d.subpage;
      end
    end
  end
endmodule

// File: rtl/sec_attr_unit_chk.sv
module sec_attr_unit_chk #(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lookup_i,
  input logic [1:0]       ctrl_i,
  input logic             cur_secure_i,
  input logic             ext_exempt_i,
  input logic             ext_ns_i,
  input logic             ext_nsc_i,
  input logic             valid_o,
  input logic             ns_o,
  input logic             nsc_o,
  input logic [IDX_W-1:0] rgn_idx_o,
  input logic             rgn_hit_o,
  input logic             subpage_o
);
  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(lookup_i));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |=> $stable({ns_o, nsc_o, rgn_idx_o, rgn_hit_o, subpage_o}));

  assert_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ns_o && nsc_o));

  assert_all_secure_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(ctrl_i) == 2'b00 && !$past(ext_exempt_i))
      |-> (!ns_o && !nsc_o && !rgn_hit_o));

  assert_all_ns_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(ctrl_i) == 2'b10 && !$past(ext_exempt_i) && $past(ext_ns_i))
      |-> (ns_o && !rgn_hit_o));

  assert_idx_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rgn_hit_o) |-> (rgn_idx_o == '0));

  assert_hit_needs_chk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && rgn_hit_o) |-> ($past(ctrl_i[0]) && !$past(ext_exempt_i)));

  assert_ext_secure_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(ext_exempt_i) && !$past(ext_ns_i) && !$past(ext_nsc_i))
      |-> (!ns_o && !nsc_o));

  assert_exempt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(ext_exempt_i))
      |-> (ns_o == !$past(cur_secure_i) && !nsc_o && !rgn_hit_o && !subpage_o));
endmodule

bind sec_attr_unit sec_attr_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lookup_i    (lookup_i),
  .ctrl_i      (ctrl_i),
  .cur_secure_i(cur_secure_i),
  .ext_exempt_i(ext_exempt_i),
  .ext_ns_i    (ext_ns_i),
  .ext_nsc_i   (ext_nsc_i),
  .valid_o     (valid_o),
  .ns_o        (ns_o),
  .nsc_o       (nsc_o),
  .rgn_idx_o   (rgn_idx_o),
  .rgn_hit_o   (rgn_hit_o),
  .subpage_o   (subpage_o)
);

// File: tb/sec_attr_unit_bench.sv
module sec_attr_unit_bench;
  localparam int unsigned AW = 32;
  localparam int unsigned NR = 8;
  localparam int unsigned PB = 12;
  localparam int unsigned IW = 3;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           lookup_i = 1'b0;
  logic [AW-1:0]  addr_i = '0;
  logic           cur_secure_i = 1'b0;
  logic [1:0]     ctrl_i = 2'b00;
  logic [NR*AW-1:0] rgn_base_i, rgn_limit_i;
  logic           ext_exempt_i = 1'b0, ext_ns_i = 1'b1, ext_nsc_i = 1'b0;
  logic           valid_o, ns_o, nsc_o, rgn_hit_o, subpage_o;
  logic [IW-1:0]  rgn_idx_o;

  logic [AW-1:0] base_a [NR];
  logic [AW-1:0] lim_a  [NR];

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic e_ns, e_nsc, e_hit, e_sub;
  logic [IW-1:0] e_idx;

  always #4 clk_i = ~clk_i;

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      rgn_base_i[r*AW +: AW]  = base_a[r];
      rgn_limit_i[r*AW +: AW] = lim_a[r];
    end
  end

  sec_attr_unit #(.ADDR_W(AW), .NUM_RGN(NR), .PAGE_BITS(PB)) u_sec_attr_unit (
    .clk_i, .rst_ni, .lookup_i, .addr_i, .cur_secure_i, .ctrl_i,
    .rgn_base_i, .rgn_limit_i, .ext_exempt_i, .ext_ns_i, .ext_nsc_i,
    .valid_o, .ns_o, .nsc_o, .rgn_idx_o, .rgn_hit_o, .subpage_o
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic predict();
    int cnt = 0;
    int k = 0;
    logic [AW-1:0] lo, hi, plo, phi;
    e_ns = 0; e_nsc = 0; e_hit = 0; e_sub = 0; e_idx = '0;
    if (ext_exempt_i) begin
      e_ns = !cur_secure_i;
      return;
    end
    if (ctrl_i[0]) begin
      plo = addr_i & ~AW'((1 << PB) - 1);
      phi = addr_i |  AW'((1 << PB) - 1);
      for (int r = 0; r < NR; r++) begin
        lo = base_a[r] & ~32'h1f;
        hi = lim_a[r]  |  32'h1f;
        if (lim_a[r][0]) begin
          if (addr_i >= lo && addr_i <= hi) begin
            if (cnt == 0) k = r;
            cnt++;
          end
          if (lo <= phi && hi >= plo && (lo > plo || hi < phi)) e_sub = 1;
        end
      end
      if (cnt == 1) begin
        e_hit = 1; e_idx = IW'(k);
        e_nsc = lim_a[k][1]; e_ns = !lim_a[k][1];
      end
    end else if (ctrl_i[1]) e_ns = 1;
    if (!ext_ns_i && (e_ns || (e_nsc && !ext_nsc_i))) begin
      e_ns = 0; e_nsc = ext_nsc_i;
    end
  endtask

  // called at a negedge with inputs already set
  task automatic lookup(input string tag);
    predict();
    lookup_i = 1'b1;
    @(negedge clk_i);
    lookup_i = 1'b0;
    check({tag, " valid"}, 32'(valid_o), 32'd1);
    check({tag, " ns"}, 32'(ns_o), 32'(e_ns));
    check({tag, " nsc"}, 32'(nsc_o), 32'(e_nsc));
    check({tag, " hit"}, 32'(rgn_hit_o), 32'(e_hit));
    check({tag, " idx"}, 32'(rgn_idx_o), 32'(e_idx));
    check({tag, " subpage"}, 32'(subpage_o), 32'(e_sub));
    check("R10 ns/nsc exclusive", 32'(ns_o && nsc_o), 32'd0);
  endtask

  task automatic set_rgn(input int r, input logic [AW-1:0] b, input logic [AW-1:0] l,
                         input logic nsc, input logic en);
    base_a[r] = b;
    lim_a[r]  = {l[AW-1:2], nsc, en};
  endtask

  initial begin
    void'($urandom(32'h5eed_2024));
    for (int r = 0; r < NR; r++) begin base_a[r] = '0; lim_a[r] = '0; end
    #20;
    @(negedge clk_i);
    check("R9 reset valid", 32'(valid_o), 0);
    check("R9 reset flags", {27'd0, ns_o, nsc_o, rgn_hit_o, subpage_o, 1'b0}, 0);
    check("R9 reset idx", 32'(rgn_idx_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 modes without checking
    addr_i = 32'h1800; ctrl_i = 2'b00; lookup("R1 all secure");
    ctrl_i = 2'b10; lookup("R1 all nonsecure");

    // R2/R3 single window, inclusive edges
    ctrl_i = 2'b01;
    set_rgn(2, 32'h1000, 32'h1fe0, 1'b0, 1'b1);
    addr_i = 32'h1800; lookup("R3 single hit ns");
    addr_i = 32'h1fff; lookup("R2 limit edge");
    addr_i = 32'h1000; lookup("R2 base edge");
    addr_i = 32'h0fff; lookup("R5 below base");
    set_rgn(2, 32'h1000, 32'h1fe0, 1'b0, 1'b0);
    addr_i = 32'h1800; lookup("R2 disabled window");
    set_rgn(2, 32'h101f, 32'h1fe0, 1'b0, 1'b1);
    addr_i = 32'h1000; lookup("R2 base low bits ignored");

    // R3 callable window and R8 sub-page
    set_rgn(5, 32'h3000, 32'h30e0, 1'b1, 1'b1);
    addr_i = 32'h3010; lookup("R3 callable hit");
    addr_i = 32'h3800; lookup("R8 same page no hit");

    // R4 overlap
    set_rgn(6, 32'h1800, 32'h18e0, 1'b0, 1'b1);
    addr_i = 32'h1810; lookup("R4 two hits");

    // R6 merge
    addr_i = 32'h1c00; ext_ns_i = 0; ext_nsc_i = 0; lookup("R6 ext secure over ns");
    ext_nsc_i = 1; lookup("R6 ext callable over ns");
    addr_i = 32'h3010; lookup("R6 both callable");
    ext_nsc_i = 0; lookup("R6 ext secure over callable");
    ctrl_i = 2'b00; ext_nsc_i = 1; lookup("R6 secure stays");
    ext_ns_i = 1; ext_nsc_i = 0;

    // R7 exempt
    ctrl_i = 2'b01; ext_exempt_i = 1; cur_secure_i = 1; addr_i = 32'h3010;
    lookup("R7 exempt secure state");
    cur_secure_i = 0; lookup("R7 exempt nonsecure state");
    ext_exempt_i = 0;

    // R9 hold without lookup
    addr_i = 32'h1c00; lookup("R9 before hold");
    addr_i = 32'h3010; ctrl_i = 2'b10;
    @(negedge clk_i);
    check("R9 hold valid low", 32'(valid_o), 0);
    check("R9 hold ns", 32'(ns_o), 32'(e_ns));
    check("R9 hold nsc", 32'(nsc_o), 32'(e_nsc));
    check("R9 hold hit", 32'(rgn_hit_o), 32'(e_hit));
    check("R9 hold idx", 32'(rgn_idx_o), 32'(e_idx));

    // random mix
    for (int t = 0; t < 400; t++) begin
      for (int r = 0; r < NR; r++) begin
        logic [AW-1:0] b;
        b = AW'($urandom_range(0, 32'h3fff));
        set_rgn(r, b, b + AW'($urandom_range(0, 32'h0800)),
                1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0));
      end
      addr_i       = AW'($urandom_range(0, 32'h47ff));
      ctrl_i       = 2'($urandom_range(0, 3));
      cur_secure_i = 1'($urandom_range(0, 1));
      ext_exempt_i = ($urandom_range(0, 7) == 0);
      ext_ns_i     = ($urandom_range(0, 3) != 0);
      ext_nsc_i    = 1'($urandom_range(0, 1));
      lookup("R3 R4 R6 R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule